// File: doc/BRIEF.md
# Packet-Driven Streaming Memory Element

This block is a memory node for a streaming compute array. Its store is a two-port RAM with one read port and one write port. A configuration input picks one of two personalities. As an addressable RAM, it turns every read-address packet into one read-data packet. It commits a write only when an address packet and a data packet are presented together. As a FIFO, it takes data packets on the write-data channel and hands them out on the output channel in the order they arrived.

Every channel uses a valid/ready handshake. A packet moves on a clock edge where both valid and ready are high. A separate configuration write port can preload the store, for example to use it as a lookup table. That port has priority over packet writes.

Data packets are 32 bits wide. The depth is a parameter, 256 words by default, and must be a power of two.

Top module: `pkt_mem_elem`

## Requirements
- R1: In RAM mode (cfgMode = 0), a read-address packet accepted on a clock edge makes outValid high after that edge. outData then holds the word stored at that address. Each accepted address yields exactly one output packet.
- R2: While outValid is high and outReady is low, outData and outValid stay unchanged and rdAddrReady is low. When outReady rises, a waiting read address is accepted on the same edge that the held packet leaves.
- R3: In RAM mode, a write is accepted only when wrAddrValid and wrDataValid are both high, and then both channels are accepted on the same edge. A lone address packet or a lone data packet is not accepted and leaves the memory unchanged.
- R4: A read and a write to the same address on the same edge return the old contents. The new value is returned by later reads.
- R5: A high cfgWe writes cfgData to cfgAddr on that edge. In that cycle wrAddrReady and wrDataReady are low.
- R6: In FIFO mode (cfgMode = 1), data packets come out on the output channel in the order they were accepted.
- R7: In FIFO mode, wrDataReady falls once the RAM holds DEPTH words. With outReady held low, exactly DEPTH+1 packets are accepted, because one of them waits in the output register.
- R8: In FIFO mode, outValid stays low while nothing is stored.
- R9: In the first cycle after cfgMode changes, all ready outputs are low. That edge clears outValid and empties the FIFO.
- R10: In FIFO mode, rdAddrReady and wrAddrReady are held low.
- R11: After reset the block is in RAM mode, outValid is low and rdAddrReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 1 | 0 = addressable RAM, 1 = FIFO |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | AW | Configuration write address |
| cfgData | input | DW | Configuration write data |
| rdAddrValid | input | 1 | Read-address packet valid |
| rdAddrReady | output | 1 | Read-address packet ready |
| rdAddr | input | AW | Read address |
| wrAddrValid | input | 1 | Write-address packet valid |
| wrAddrReady | output | 1 | Write-address packet ready |
| wrAddr | input | AW | Write address |
| wrDataValid | input | 1 | Write-data packet valid |
| wrDataReady | output | 1 | Write-data packet ready |
| wrData | input | DW | Write data |
| outValid | output | 1 | Output packet valid |
| outReady | input | 1 | Output packet ready |
| outData | output | DW | Output packet data |

## Verification
Two pairs of functions can land on the same edge: a packet read with a packet write to the same address, and a configuration write with a packet write. For the first pair, the bench raises both handshakes in one cycle with matching addresses. It expects the old word in the response and the new word on the next read. For the second pair, the bench drives cfgWe alongside a complete write pair. It expects the packet readies to be low in that cycle and to rise in the next one. It then reads both locations back to confirm that each write landed where it was aimed.

// File: rtl/pkt_mem_pkg.sv
package pkt_mem_pkg;
  typedef enum logic {MODE_RAM = 1'b0, MODE_FIFO = 1'b1} memMode_e;

  typedef struct packed {
    logic memWr;     // write port strobe
    logic useCfg;    // write port takes configuration data
    logic memRd;     // read port strobe, loads the output register
    logic outClear;  // drop the output register (mode change)
  } memStrb_t;
endpackage

// File: rtl/pkt_mem_ctrl.sv
module pkt_mem_ctrl
  import pkt_mem_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgMode,
  input  logic          cfgWe,
  input  logic [AW-1:0] cfgAddr,
  input  logic          rdAddrValid,
  input  logic [AW-1:0] rdAddr,
  input  logic          wrAddrValid,
  input  logic [AW-1:0] wrAddr,
  input  logic          wrDataValid,
  input  logic          outValid,
  input  logic          outReady,
  output logic          rdAddrReady,
  output logic          wrAddrReady,
  output logic          wrDataReady,
  output memStrb_t      strb,
  output logic [AW-1:0] memWa,
  output logic [AW-1:0] memRa
);
  memMode_e      modeQ;
  logic          modeChg;
  logic          outFree;
  logic [PW-1:0] wrPtr, rdPtr, fillCnt;
  logic          fifoFull, fifoEmpty;
  logic          pushEn, popEn;

  assign modeChg   = (memMode_e'(cfgMode) != modeQ);
  assign outFree   = !outValid || outReady;
  assign fillCnt   = wrPtr - rdPtr;
  assign fifoFull  = (fillCnt == PW'(DEPTH));
  assign fifoEmpty = (wrPtr == rdPtr);

  always_comb begin
    rdAddrReady = 1'b0;
    wrAddrReady = 1'b0;
    wrDataReady = 1'b0;
    if (!modeChg) begin
      if (modeQ == MODE_RAM) begin
        rdAddrReady = outFree;
        wrAddrReady = wrAddrValid && wrDataValid && !cfgWe;
        wrDataReady = wrAddrValid && wrDataValid && !cfgWe;
      end else begin
        wrDataReady = !fifoFull && !cfgWe;
      end
    end
  end

  assign pushEn = (modeQ == MODE_FIFO) && wrDataValid && wrDataReady;
  assign popEn  = (modeQ == MODE_FIFO) && !modeChg && !fifoEmpty && outFree;

  always_comb begin
    strb          = '0;
    strb.useCfg   = cfgWe;
    strb.memWr    = cfgWe || (wrDataValid && wrDataReady);
    strb.outClear = modeChg;
    if (modeQ == MODE_RAM) begin
      strb.memRd = rdAddrValid && rdAddrReady;
      memRa      = rdAddr;
      memWa      = cfgWe ? cfgAddr : wrAddr;
    end else begin
      strb.memRd = popEn;
      memRa      = rdPtr[AW-1:0];
      memWa      = cfgWe ? cfgAddr : wrPtr[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_RAM;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      modeQ <= memMode_e'(cfgMode);
      if (modeChg) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (pushEn) wrPtr <= wrPtr + 1'b1;
        if (popEn)  rdPtr <= rdPtr + 1'b1;
      end
    end
  end

  // R3: an address packet never goes without its data packet
  p_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrAddrValid && wrAddrReady) |-> (wrDataValid && wrDataReady));
  // R5: configuration writes lock out packet writes
  p_cfg_prio_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |-> !(wrDataValid && wrDataReady));
  // R7: the RAM never holds more than DEPTH words
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_FIFO) |-> (fillCnt <= PW'(DEPTH)));
  // R10: address channels are closed in FIFO mode
  p_fifo_addr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_FIFO) |-> (!rdAddrReady && !wrAddrReady));
  // R9: a mode change leaves the queue empty
  p_flush_r9: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> (wrPtr == rdPtr));
endmodule

// File: rtl/pkt_mem_dpath.sv
module pkt_mem_dpath
  import pkt_mem_pkg::*;
#(
  parameter int DW = 32,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  memStrb_t      strb,
  input  logic [AW-1:0] memWa,
  input  logic [AW-1:0] memRa,
  input  logic [DW-1:0] cfgData,
  input  logic [DW-1:0] wrData,
  input  logic          outReady,
  output logic          outValid,
  output logic [DW-1:0] outData
);
  logic [DW-1:0] memArr [DEPTH];

  // Nonblocking read and write on the same edge: the read sees old contents.
  always_ff @(posedge clk) begin
    if (strb.memWr) memArr[memWa] <= strb.useCfg ? cfgData : wrData;
    if (strb.memRd) outData <= memArr[memRa];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              outValid <= 1'b0;
    else if (strb.outClear) outValid <= 1'b0;
    else if (strb.memRd)    outValid <= 1'b1;
    else if (outReady)      outValid <= 1'b0;
  end

  // R2: a stalled response holds still
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !strb.outClear) |=> (outValid && $stable(outData)));
  // R1: every read strobe produces a valid packet
  p_resp_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memRd && !strb.outClear) |=> outValid);
endmodule

// File: rtl/pkt_mem_elem.sv
module pkt_mem_elem
  import pkt_mem_pkg::*;
#(
  parameter int DW = 32,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgMode,
  input  logic          cfgWe,
  input  logic [AW-1:0] cfgAddr,
  input  logic [DW-1:0] cfgData,
  input  logic          rdAddrValid,
  output logic          rdAddrReady,
  input  logic [AW-1:0] rdAddr,
  input  logic          wrAddrValid,
  output logic          wrAddrReady,
  input  logic [AW-1:0] wrAddr,
  input  logic          wrDataValid,
  output logic          wrDataReady,
  input  logic [DW-1:0] wrData,
  output logic          outValid,
  input  logic          outReady,
  output logic [DW-1:0] outData
);
  memStrb_t      strb;
  logic [AW-1:0] memWa, memRa;

  pkt_mem_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .rdAddrValid(rdAddrValid), .rdAddr(rdAddr),
    .wrAddrValid(wrAddrValid), .wrAddr(wrAddr), .wrDataValid(wrDataValid),
    .outValid(outValid), .outReady(outReady),
    .rdAddrReady(rdAddrReady), .wrAddrReady(wrAddrReady), .wrDataReady(wrDataReady),
    .strb(strb), .memWa(memWa), .memRa(memRa)
  );

  pkt_mem_dpath #(.DW(DW), .DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .memWa(memWa), .memRa(memRa),
    .cfgData(cfgData), .wrData(wrData), .outReady(outReady),
    .outValid(outValid), .outData(outData)
  );
endmodule

// File: tb/pkt_mem_elem_tb.sv
`timescale 1ns/1ps
module pkt_mem_elem_tb_top;
  localparam int DW = 32;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);
  localparam int NV = 8;
  // {address, data}
  localparam logic [AW+DW-1:0] VEC [NV] = '{
    {8'h00, 32'h1111_0000}, {8'hFF, 32'hDEAD_BEEF}, {8'h05, 32'h0000_0001},
    {8'h80, 32'hFFFF_FFFF}, {8'h7F, 32'h8000_0000}, {8'h33, 32'hA5A5_5A5A},
    {8'h01, 32'h0000_0000}, {8'hC0, 32'h1234_5678}};

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgMode = 1'b0, cfgWe = 1'b0;
  logic [AW-1:0] cfgAddr = '0, rdAddr = '0, wrAddr = '0;
  logic [DW-1:0] cfgData = '0, wrData = '0;
  logic rdAddrValid = 1'b0, wrAddrValid = 1'b0, wrDataValid = 1'b0, outReady = 1'b0;
  logic rdAddrReady, wrAddrReady, wrDataReady, outValid;
  logic [DW-1:0] outData;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pkt_mem_elem #(.DW(DW), .DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ramWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrAddr = a; wrData = d; wrAddrValid = 1'b1; wrDataValid = 1'b1;
    #1;
    while (!wrAddrReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wrAddrValid = 1'b0; wrDataValid = 1'b0;
  endtask

  task automatic ramRead(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rdAddr = a; rdAddrValid = 1'b1; outReady = 1'b1;
    #1;
    while (!rdAddrReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    rdAddrValid = 1'b0;
    @(negedge clk);
    chk("R1 valid", {31'b0, outValid}, 32'd1);
    d = outData;
  endtask

  task automatic fifoPush(input logic [DW-1:0] d);
    @(negedge clk);
    wrData = d; wrDataValid = 1'b1;
    #1;
    while (!wrDataReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wrDataValid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    int cnt;
    bit stop;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 outValid", {31'b0, outValid}, 32'd0);
    chk("R11 rdAddrReady", {31'b0, rdAddrReady}, 32'd1);

    // R1 table walk: write every vector, then read each back
    for (int i = 0; i < NV; i++) ramWrite(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
    for (int i = 0; i < NV; i++) begin
      ramRead(VEC[i][AW+DW-1:DW], rd);
      chk("R1 data", rd, VEC[i][DW-1:0]);
    end

    // R2 back-pressure hold and pipelined handover
    ramWrite(8'd10, 32'hAAAA_0010);
    ramWrite(8'd11, 32'hBBBB_0011);
    @(negedge clk); outReady = 1'b0; rdAddr = 8'd10; rdAddrValid = 1'b1;
    @(posedge clk); #1; rdAddr = 8'd11;
    @(negedge clk);
    chk("R2 valid", {31'b0, outValid}, 32'd1);
    chk("R2 data", outData, 32'hAAAA_0010);
    chk("R2 addr blocked", {31'b0, rdAddrReady}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R2 data held", outData, 32'hAAAA_0010);
    outReady = 1'b1; #1;
    chk("R2 addr reopens", {31'b0, rdAddrReady}, 32'd1);
    @(posedge clk); #1; rdAddrValid = 1'b0;
    @(negedge clk);
    chk("R1 second packet", outData, 32'hBBBB_0011);
    chk("R1 second valid", {31'b0, outValid}, 32'd1);
    @(negedge clk);
    chk("R1 one packet per address", {31'b0, outValid}, 32'd0);

    // R3 lone address / lone data not accepted
    ramWrite(8'd40, 32'h4040_4040);
    @(negedge clk); wrAddr = 8'd40; wrData = 32'h0BAD_0001; wrAddrValid = 1'b1; #1;
    chk("R3 lone addr", {31'b0, wrAddrReady}, 32'd0);
    @(posedge clk); #1; wrAddrValid = 1'b0; wrDataValid = 1'b1; wrData = 32'h0BAD_0002; #1;
    chk("R3 lone data", {31'b0, wrDataReady}, 32'd0);
    @(posedge clk); #1; wrDataValid = 1'b0;
    ramRead(8'd40, rd);
    chk("R3 memory unchanged", rd, 32'h4040_4040);

    // R4 same-address read and write on one edge
    ramWrite(8'd20, 32'h0000_0D1D);
    @(negedge clk);
    rdAddr = 8'd20; rdAddrValid = 1'b1; outReady = 1'b1;
    wrAddr = 8'd20; wrData = 32'h0000_0E3E; wrAddrValid = 1'b1; wrDataValid = 1'b1;
    #1;
    chk("R4 write ready", {31'b0, wrAddrReady}, 32'd1);
    @(posedge clk); #1;
    rdAddrValid = 1'b0; wrAddrValid = 1'b0; wrDataValid = 1'b0;
    @(negedge clk);
    chk("R4 old data", outData, 32'h0000_0D1D);
    ramRead(8'd20, rd);
    chk("R4 new data later", rd, 32'h0000_0E3E);

    // R5 configuration write beats a packet write
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 8'd30; cfgData = 32'hC0F1_6030;
    wrAddr = 8'd31; wrData = 32'h9AC4_E031; wrAddrValid = 1'b1; wrDataValid = 1'b1;
    #1;
    chk("R5 packet blocked", {31'b0, wrAddrReady}, 32'd0);
    @(posedge clk); #1; cfgWe = 1'b0;
    @(negedge clk); #1;
    chk("R5 packet resumes", {31'b0, wrAddrReady}, 32'd1);
    @(posedge clk); #1; wrAddrValid = 1'b0; wrDataValid = 1'b0;
    ramRead(8'd30, rd);
    chk("R5 preload value", rd, 32'hC0F1_6030);
    ramRead(8'd31, rd);
    chk("R5 packet value", rd, 32'h9AC4_E031);

    // R9 switch to FIFO: readies low in the change cycle
    @(negedge clk);
    cfgMode = 1'b1; outReady = 1'b0; wrDataValid = 1'b1; wrData = 32'h5757_0000; #1;
    chk("R9 switch cycle ready", {31'b0, wrDataReady}, 32'd0);
    @(posedge clk); #1; wrDataValid = 1'b0; rdAddrValid = 1'b1; wrAddrValid = 1'b1;
    @(negedge clk);
    chk("R8 empty no output", {31'b0, outValid}, 32'd0);
    chk("R10 rd addr closed", {31'b0, rdAddrReady}, 32'd0);
    chk("R10 wr addr closed", {31'b0, wrAddrReady}, 32'd0);
    rdAddrValid = 1'b0; wrAddrValid = 1'b0;

    // R6 arrival order
    for (int i = 0; i < NV; i++) fifoPush(VEC[i][DW-1:0]);
    @(negedge clk); outReady = 1'b1;
    for (int i = 0; i < NV; i++) begin
      while (!outValid) @(negedge clk);
      chk("R6 order", outData, VEC[i][DW-1:0]);
      @(negedge clk);
    end
    chk("R8 drained", {31'b0, outValid}, 32'd0);

    // R7 capacity with output stalled
    outReady = 1'b0;
    cnt = 0; stop = 1'b0;
    while (!stop && cnt < 300) begin
      @(negedge clk); wrData = 32'h1000 + cnt; wrDataValid = 1'b1; #1;
      if (!wrDataReady) stop = 1'b1;
      else begin @(posedge clk); cnt++; end
    end
    wrDataValid = 1'b0;
    chk("R7 capacity", cnt, DEPTH + 1);
    @(negedge clk);
    chk("R7 head word", outData, 32'h1000);

    // R9 mode change clears the output and the queue
    cfgMode = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 out cleared", {31'b0, outValid}, 32'd0);
    cfgMode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 queue emptied", {31'b0, outValid}, 32'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule